// File: doc/BRIEF.md
# Cartridge Register and DMA Slave

This block stands in for the controller of a game cartridge that sits on a 16-bit host bus. The host programs a ROM byte address through a pair of 16-bit register writes and then fetches ROM words one at a time. In programmed I/O, it reads a data register. In DMA mode, it programs a start address and a transfer length. The block then raises a request, and the host answers with an active-low acknowledge and a train of read strobes. Each strobe moves one word, and the internal pointer advances after each one.

Two IDE-style active-low chip selects pick the register bank and three address lines pick the register. Chip select 0 on its own selects the main bank: offset, DMA start, DMA length and the data port. Chip select 1 on its own selects the control bank: status and interrupt clear. With both selects low, or both high, no register is touched. The length register counts in 32-byte units, which is sixteen words. When the final word of a transfer has been read, the request drops and an interrupt is raised. The interrupt stays raised until the host writes the clear register.

The ROM behind the block is a computed memory model. It reads as all ones past its end, so an empty or short image behaves the way an unpopulated cartridge does. All strobes are taken as synchronous to `clk`. A write acts on the first clock after its strobe falls. A read advances state on the first clock after its strobe rises.

Top module: `cart_slave`

## Requirements
- R1: After reset, `dreq`, `irq` and `data_oe` are low, the pointer is byte address 0 and auto-increment is off.
- R2: The ROM offset is written in two halves on the main bank. Register 0 holds the low 16 bits and is only staged. Register 1 holds the high half and commits the full pointer: bits 12:0 become byte address 28:16 and bit 15 becomes the auto-increment flag. With the flag set, each read of data register 2 returns the word at the pointer and then advances the pointer by one word.
- R3: With the auto-increment flag clear, repeated reads of data register 2 return the same word.
- R4: Bits 14:13 of the high half are ignored, so a high half with top nibble 0xA addresses the same bytes as one with top nibble 0x8. A write to register 0 alone does not move the pointer.
- R5: ROM word index i, which is byte address 2i, reads as i[15:0] XOR 0xA5C3 for i below ROM_WORDS, and as 0xFFFF at or beyond ROM_WORDS.
- R6: DMA start is staged by register 3 (low half) and committed by register 4 (bits 12:0 form the high part). A nonzero write N to length register 5 loads the pointer from the committed start and raises `dreq`, with 16×N words to move.
- R7: While `dack_n` and `rd_n` are both low and `dreq` is high, `data_out` carries the word at the pointer. At the end of each such strobe the pointer advances one word, whatever the auto-increment flag holds. Exactly 16×N strobes are served, and `dreq` falls at the end of the last one.
- R8: `irq` rises together with the fall of `dreq` at the end of a transfer. It stays high until a write to control register 6. Reading control register 6 returns `dreq` in bit 1 and `irq` in bit 0.
- R9: Writing 0 to the length register starts nothing: `dreq` stays low and `irq` does not rise.
- R10: `data_out` is driven (`data_oe` high) only during a read strobe to data register 2, to control register 6, or during an acknowledged DMA read. Strobes with both chip selects high, or both low, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0_n | input | 1 | Main register bank select, active low |
| cs1_n | input | 1 | Control register bank select, active low |
| reg_addr | input | 3 | Register index within the selected bank |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| data_in | input | 16 | Write data from host |
| data_out | output | 16 | Read data to host |
| data_oe | output | 1 | High while data_out is driven |
| dreq | output | 1 | DMA request |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
A wrong pointer shows up at once as a wrong word on the very read strobe that uses it. Because the ROM model's contents depend on the index, a pointer that is off by a word, or that skips an increment, gives a different value. A bad remaining count shows as `dreq` falling one strobe too early or too late, and as `irq` rising at that same wrong point. The bench checks both on every DMA length it sweeps. A lost or stuck interrupt is visible on the status register within one read after the transfer ends or after the clear write.

// File: rtl/cart_pkg.sv
package cart_pkg;
    // main bank register indices (chip select 0)
    localparam logic [2:0] REG_OFF_LO = 3'd0;
    localparam logic [2:0] REG_OFF_HI = 3'd1;
    localparam logic [2:0] REG_DATA   = 3'd2;
    localparam logic [2:0] REG_DST_LO = 3'd3;
    localparam logic [2:0] REG_DST_HI = 3'd4;
    localparam logic [2:0] REG_LEN    = 3'd5;
    // control bank register index (chip select 1)
    localparam logic [2:0] REG_CTL    = 3'd6;

    typedef struct packed {
        logic wr_main;   // write event, main bank
        logic wr_ctl;    // write event, control bank
        logic pio_done;  // end of data-port read strobe
        logic dma_done;  // end of acknowledged read strobe
    } bus_ev_t;
endpackage

// File: rtl/cart_decode.sv
module cart_decode
    import cart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs0_n,
    input  logic       cs1_n,
    input  logic [2:0] reg_addr,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       dack_n,
    output logic       sel_main,
    output logic       sel_ctl,
    output bus_ev_t    ev
);
    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    strobe_t st_d, st_q;

    assign sel_main = !cs0_n && cs1_n;
    assign sel_ctl  = cs0_n && !cs1_n;

    always_comb begin
        st_d.rd = rd_n;
        st_d.wr = wr_n;
        ev.wr_main  = sel_main && !wr_n && st_q.wr;
        ev.wr_ctl   = sel_ctl  && !wr_n && st_q.wr;
        ev.pio_done = sel_main && (reg_addr == REG_DATA) && rd_n && !st_q.rd;
        ev.dma_done = !dack_n && rd_n && !st_q.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rd: 1'b1, wr: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cart_engine.sv
module cart_engine
    import cart_pkg::*;
#(
    parameter int ADDR_BITS  = 29,
    parameter int CNT_W      = 16,
    parameter int UNIT_BYTES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_ev_t              ev,
    input  logic [2:0]           reg_addr,
    input  logic [15:0]          data_in,
    output logic [ADDR_BITS-1:0] ptr,
    output logic                 dreq,
    output logic                 irq
);
    localparam int HI_W       = ADDR_BITS - 16;
    localparam int UNIT_SHIFT = $clog2(UNIT_BYTES / 2);
    localparam int REM_W      = CNT_W + UNIT_SHIFT;
    localparam logic [ADDR_BITS-1:0] STEP = ADDR_BITS'(2);
    localparam logic [REM_W-1:0]     ONE  = REM_W'(1);

    typedef struct packed {
        logic [ADDR_BITS-1:0] ptr;
        logic                 autoinc;
        logic [15:0]          off_lo;
        logic [15:0]          dst_lo;
        logic [ADDR_BITS-1:0] dst;
        logic [REM_W-1:0]     rem;
        logic                 dreq;
        logic                 irq;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d = q;
        if (ev.wr_main) begin
            case (reg_addr)
                REG_OFF_LO: d.off_lo = data_in;
                REG_OFF_HI: begin
                    d.ptr     = {data_in[HI_W-1:0], q.off_lo};
                    d.autoinc = data_in[15];
                end
                REG_DST_LO: d.dst_lo = data_in;
                REG_DST_HI: d.dst    = {data_in[HI_W-1:0], q.dst_lo};
                REG_LEN: begin
                    d.ptr  = q.dst;
                    d.rem  = REM_W'(data_in[CNT_W-1:0]) << UNIT_SHIFT;
                    d.dreq = |data_in[CNT_W-1:0];
                end
                default: ;
            endcase
        end
        if (ev.wr_ctl && reg_addr == REG_CTL) begin
            d.irq = 1'b0;
        end
        if (ev.pio_done && q.autoinc) begin
            d.ptr = q.ptr + STEP;
        end
        if (ev.dma_done && q.dreq) begin
            d.ptr = q.ptr + STEP;
            d.rem = q.rem - ONE;
            if (q.rem == ONE) begin
                d.dreq = 1'b0;
                d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ptr  = q.ptr;
    assign dreq = q.dreq;
    assign irq  = q.irq;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq && !(ev.wr_ctl && reg_addr == REG_CTL) |=> q.irq); // R8
    AST_DMA_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev.dma_done && q.dreq && !ev.wr_main |=> q.ptr == $past(q.ptr) + STEP); // R7
    AST_DMA_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev.dma_done && q.dreq && !ev.wr_main |=> q.rem == $past(q.rem) - ONE); // R7
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev.wr_main && reg_addr == REG_LEN && data_in[CNT_W-1:0] == '0 && !ev.dma_done
        |=> !q.dreq); // R9
    AST_PIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ev.pio_done && !q.autoinc && !ev.wr_main && !ev.dma_done |=> $stable(q.ptr)); // R3
endmodule

// File: rtl/cart_rom_model.sv
module cart_rom_model #(
    parameter int          ADDR_BITS = 29,
    parameter int          ROM_WORDS = 512,
    parameter logic [15:0] FILL_XOR  = 16'hA5C3
) (
    input  logic [ADDR_BITS-1:0] byte_addr,
    output logic [15:0]          word
);
    localparam logic [ADDR_BITS-1:0] LIMIT = ADDR_BITS'(2 * ROM_WORDS);

    always_comb begin
        if (byte_addr < LIMIT) begin
            word = byte_addr[16:1] ^ FILL_XOR;
        end else begin
            word = 16'hFFFF;
        end
    end
endmodule

// File: rtl/cart_slave.sv
module cart_slave
    import cart_pkg::*;
#(
    parameter int ADDR_BITS  = 29,
    parameter int CNT_W      = 16,
    parameter int UNIT_BYTES = 32,
    parameter int ROM_WORDS  = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs0_n,
    input  logic        cs1_n,
    input  logic [2:0]  reg_addr,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        dack_n,
    input  logic [15:0] data_in,
    output logic [15:0] data_out,
    output logic        data_oe,
    output logic        dreq,
    output logic        irq
);
    logic                 sel_main;
    logic                 sel_ctl;
    bus_ev_t              ev;
    logic [ADDR_BITS-1:0] ptr;
    logic [15:0]          rom_word;
    logic                 rd_data, rd_stat, rd_dma;

    cart_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .reg_addr (reg_addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dack_n   (dack_n),
        .sel_main (sel_main),
        .sel_ctl  (sel_ctl),
        .ev       (ev)
    );

    cart_engine #(
        .ADDR_BITS  (ADDR_BITS),
        .CNT_W      (CNT_W),
        .UNIT_BYTES (UNIT_BYTES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .reg_addr (reg_addr),
        .data_in  (data_in),
        .ptr      (ptr),
        .dreq     (dreq),
        .irq      (irq)
    );

    cart_rom_model #(
        .ADDR_BITS (ADDR_BITS),
        .ROM_WORDS (ROM_WORDS)
    ) u_rom (
        .byte_addr (ptr),
        .word      (rom_word)
    );

    always_comb begin
        rd_data = !rd_n && sel_main && (reg_addr == REG_DATA);
        rd_stat = !rd_n && sel_ctl  && (reg_addr == REG_CTL);
        rd_dma  = !rd_n && !dack_n && dreq;
        data_oe = rd_data || rd_stat || rd_dma;
        if (rd_stat) begin
            data_out = {14'd0, dreq, irq};
        end else if (rd_data || rd_dma) begin
            data_out = rom_word;
        end else begin
            data_out = 16'd0;
        end
    end

    AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rd_n); // R10
    AST_DREQ_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dreq) && !$past(wr_n) == 1'b0 |-> irq || $past(!wr_n)); // R8
endmodule

// File: tb/test_cart_slave.sv
module test_cart_slave;
    import cart_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ROM_WORDS  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs0_n = 1'b1, cs1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] data_in = 16'd0;
    logic [15:0] data_out;
    logic        data_oe, dreq, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cart_slave #(.ROM_WORDS(ROM_WORDS)) i_cart_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .reg_addr (reg_addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dack_n   (dack_n),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe),
        .dreq     (dreq),
        .irq      (irq)
    );

    function automatic logic [15:0] rom(input int w);
        if (w < ROM_WORDS) return 16'(w) ^ 16'hA5C3;
        return 16'hFFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        cs0_n = c0; cs1_n = c1; reg_addr = a; data_in = v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs0_n = 1'b1; cs1_n = 1'b1;
    endtask

    task automatic bus_rd(input logic c0, input logic c1, input logic [2:0] a,
                          output logic [15:0] v, output logic oe);
        @(negedge clk);
        cs0_n = c0; cs1_n = c1; reg_addr = a; rd_n = 1'b0;
        @(negedge clk);
        v = data_out; oe = data_oe;
        rd_n = 1'b1;
        @(negedge clk);
        cs0_n = 1'b1; cs1_n = 1'b1;
    endtask

    task automatic dma_rd(output logic [15:0] v);
        @(negedge clk);
        dack_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        v = data_out;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_offset(input int byte_addr, input logic [15:0] flags);
        bus_wr(1'b0, 1'b1, REG_OFF_LO, byte_addr[15:0]);
        bus_wr(1'b0, 1'b1, REG_OFF_HI, flags | {3'b000, byte_addr[28:16]});
    endtask

    initial begin
        logic [15:0] v;
        logic        oe;
        int          bases [4];
        int          hold_w;
        bases = '{0, 5, 300, ROM_WORDS - 3};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dreq", {31'd0, dreq}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 oe", {31'd0, data_oe}, 32'd0);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R1 first word", {16'd0, v}, {16'd0, rom(0)});
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R1 no autoinc", {16'd0, v}, {16'd0, rom(0)});

        // R2/R4/R5: sweep offsets with top nibble 0xA (flag bits 14:13 partly set)
        foreach (bases[b]) begin
            set_offset(bases[b] * 2, 16'hA000);
            for (int k = 0; k < 6; k++) begin
                bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
                chk("R2 R5 pio autoinc word", {16'd0, v}, {16'd0, rom(bases[b] + k)});
                chk("R10 oe on data read", {31'd0, oe}, 32'd1);
            end
        end
        // R4: high nibble 0x8 reaches same word as 0xA
        set_offset(300 * 2, 16'h8000);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R4 flag bits ignored", {16'd0, v}, {16'd0, rom(300)});
        // R5: far beyond ROM through high half
        set_offset(32'h0010_0000, 16'h0000);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R5 beyond rom", {16'd0, v}, 32'h0000_FFFF);

        // R3: auto-increment off
        hold_w = 77;
        set_offset(hold_w * 2, 16'h2000);
        for (int k = 0; k < 3; k++) begin
            bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
            chk("R3 hold word", {16'd0, v}, {16'd0, rom(hold_w)});
        end
        // R4: low half alone does not move the pointer
        bus_wr(1'b0, 1'b1, REG_OFF_LO, 16'd400);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R4 low half staged only", {16'd0, v}, {16'd0, rom(hold_w)});
        // R10: deselected and double-selected writes change nothing
        bus_wr(1'b1, 1'b1, REG_OFF_HI, 16'h8000);
        bus_wr(1'b0, 1'b0, REG_OFF_HI, 16'h8000);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R10 ignored writes", {16'd0, v}, {16'd0, rom(hold_w)});
        bus_rd(1'b1, 1'b1, REG_DATA, v, oe);
        chk("R10 no oe when deselected", {31'd0, oe}, 32'd0);
        bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
        chk("R10 ptr kept", {16'd0, v}, {16'd0, rom(hold_w)});

        // R6/R7/R8: DMA sweep over lengths 1..3 (autoinc flag still clear)
        for (int n = 1; n <= 3; n++) begin
            int s;
            s = 40 * n;
            bus_wr(1'b0, 1'b1, REG_DST_LO, 16'(s * 2));
            bus_wr(1'b0, 1'b1, REG_DST_HI, 16'hA000);
            chk("R6 no dreq before length", {31'd0, dreq}, 32'd0);
            bus_wr(1'b0, 1'b1, REG_LEN, 16'(n));
            chk("R6 dreq raised", {31'd0, dreq}, 32'd1);
            for (int k = 0; k < 16 * n; k++) begin
                if (k == 16 * n - 1) begin
                    chk("R7 dreq before last", {31'd0, dreq}, 32'd1);
                    chk("R8 irq before last", {31'd0, irq}, 32'd0);
                end
                dma_rd(v);
                chk("R7 dma word", {16'd0, v}, {16'd0, rom(s + k)});
            end
            dack_n = 1'b1;
            chk("R7 dreq dropped", {31'd0, dreq}, 32'd0);
            chk("R8 irq raised", {31'd0, irq}, 32'd1);
            bus_rd(1'b0, 1'b1, REG_DATA, v, oe);
            chk("R7 ptr after dma", {16'd0, v}, {16'd0, rom(s + 16 * n)});
            repeat (5) @(negedge clk);
            bus_rd(1'b1, 1'b0, REG_CTL, v, oe);
            chk("R8 status irq held", {16'd0, v}, 32'h0000_0001);
            bus_wr(1'b1, 1'b0, REG_CTL, 16'd0);
            chk("R8 irq cleared", {31'd0, irq}, 32'd0);
        end

        // R9: zero length starts nothing
        bus_wr(1'b0, 1'b1, REG_LEN, 16'd0);
        repeat (3) @(negedge clk);
        chk("R9 no dreq", {31'd0, dreq}, 32'd0);
        chk("R9 no irq", {31'd0, irq}, 32'd0);
        bus_rd(1'b1, 1'b0, REG_CTL, v, oe);
        chk("R9 status idle", {16'd0, v}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule